// File: doc/BRIEF.md
# Once-Per-Second Interrupt Generator

This block turns a once-per-second event into a seconds flag and an interrupt request. The seconds event comes from a seconds counter that is outside this block. A 64 Hz tick, from the same divider chain, sets the width of the pulsed interrupt. An enable input switches the function on and off. A mode input picks between two interrupt forms:

- **Pulse mode:** the interrupt is a pulse once per second, lasting exactly one 64 Hz period.
- **Level mode:** the interrupt is a level that follows the flag until the host clears the flag.

The block has no link to any countdown or watchdog timer. The host clears the flag with a single-cycle write strobe. Nothing else clears it.

All inputs are plain control strobes and levels sampled on `clk_i`. No data moves through the block, so there is no valid/ready handshake and no back-pressure. The interrupt output is a combinational select from registered state, gated by the enable input.

Top module: `sif_sec_irq`

## Requirements
- R1: During and after reset, until the first enabled seconds event, `sec_flag_o` and `irq_o` are 0.
- R2: When `enable_i`=1 and `sec_inc_i`=1 at a rising clock edge, `sec_flag_o` is 1 after that edge.
- R3: When `enable_i`=0, `sec_inc_i` does not set the flag and does not arm a pulse. `irq_o` stays 0.
- R4: Once set, `sec_flag_o` stays 1 until a clock edge with `flag_clr_i`=1. The flag is 0 after such an edge, unless the same edge also carries an enabled `sec_inc_i`, in which case the set wins and the flag stays 1.
- R5: In pulse mode (`pulse_mode_i`=1), an enabled `sec_inc_i` together with `tick64_i` makes `irq_o` 1 after that edge. `irq_o` returns to 0 after the next edge that has `tick64_i`=1, so the pulse lasts one 64 Hz period.
- R6: In pulse mode, an enabled `sec_inc_i` without `tick64_i` arms the pulse. The pulse then starts after the next edge that has `tick64_i`=1.
- R7: In level mode (`pulse_mode_i`=0) with `enable_i`=1, `irq_o` equals `sec_flag_o`. It therefore falls after the edge that clears the flag.
- R8: Driving `enable_i` to 0 forces `irq_o` to 0 in the same cycle, without waiting for a clock edge. It cancels any pulse in progress or armed, and leaves `sec_flag_o` unchanged.
- R9: In pulse mode, clearing the flag does not shorten the pulse. The pulse also ends on its tick whether or not the flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick64_i | input | 1 | One-cycle strobe at 64 Hz |
| sec_inc_i | input | 1 | One-cycle strobe when the seconds counter increments |
| enable_i | input | 1 | 1 turns the seconds interrupt function on |
| pulse_mode_i | input | 1 | 1 = pulsed interrupt, 0 = level interrupt |
| flag_clr_i | input | 1 | Host write strobe that clears the seconds flag |
| sec_flag_o | output | 1 | Seconds flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bound checker watches several rules on every cycle:
- An enabled seconds event always sets the flag (R2).
- The flag never rises without an enabled event and never falls without a clear (R4).
- A disabled block never asserts the interrupt (R3, R8).
- In level mode the interrupt mirrors the flag (R7).
- A pulse can only begin on a tick edge (R5).

The directed scenarios cover what a single-cycle property cannot:
- The exact one-tick width of a pulse (R5).
- The deferred start of a pulse armed between ticks (R6).
- Set-over-clear priority (R4).
- A flag clear in the middle of a pulse (R9).
- The flag keeping its value when enable drops mid-pulse (R8).

// File: rtl/sif_pkg.sv
package sif_pkg;
  typedef enum logic {
    MODE_LEVEL = 1'b0,
    MODE_PULSE = 1'b1
  } irq_mode_e;
endpackage

// File: rtl/sif_flag_reg.sv
module sif_flag_reg #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  generate
    if (SET_WINS) begin : g_set_wins
      always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
      end
    end else begin : g_clr_wins
      always_comb begin
        flag_d = flag_q;
        if (set_i) flag_d = 1'b1;
        if (clr_i) flag_d = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/sif_pulse_gen.sv
module sif_pulse_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic tick_i,
  input  logic trig_i,
  output logic pulse_o
);
  logic pend_q, pulse_q;
  logic start;

  // A pulse begins on a tick once triggered (now or earlier)
  assign start = enable_i & tick_i & (trig_i | pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else if (!enable_i) begin
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (start)       pend_q <= 1'b0;
      else if (trig_i) pend_q <= 1'b1;

      if (start)       pulse_q <= 1'b1;
      else if (tick_i) pulse_q <= 1'b0;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/sif_irq_sel.sv
module sif_irq_sel
  import sif_pkg::*;
(
  input  logic      enable_i,
  input  irq_mode_e mode_i,
  input  logic      flag_i,
  input  logic      pulse_i,
  output logic      irq_o
);
  always_comb begin
    unique case (mode_i)
      MODE_PULSE: irq_o = enable_i & pulse_i;
      default:    irq_o = enable_i & flag_i;
    endcase
  end
endmodule

// File: rtl/sif_sec_irq.sv
module sif_sec_irq
  import sif_pkg::*;
#(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick64_i,
  input  logic sec_inc_i,
  input  logic enable_i,
  input  logic pulse_mode_i,
  input  logic flag_clr_i,
  output logic sec_flag_o,
  output logic irq_o
);
  logic      sec_evt;
  logic      pulse;
  irq_mode_e mode;

  assign sec_evt = enable_i & sec_inc_i;
  assign mode    = irq_mode_e'(pulse_mode_i);

  sif_flag_reg #(.SET_WINS(SET_WINS)) u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sec_evt),
    .clr_i  (flag_clr_i),
    .flag_o (sec_flag_o)
  );

  sif_pulse_gen u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .tick_i   (tick64_i),
    .trig_i   (sec_evt),
    .pulse_o  (pulse)
  );

  sif_irq_sel u_sel (
    .enable_i (enable_i),
    .mode_i   (mode),
    .flag_i   (sec_flag_o),
    .pulse_i  (pulse),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/sif_sec_irq_chk.sv
module sif_sec_irq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick64_i,
  input logic sec_inc_i,
  input logic enable_i,
  input logic pulse_mode_i,
  input logic flag_clr_i,
  input logic sec_flag_o,
  input logic irq_o
);
  // R2
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && sec_inc_i |=> sec_flag_o);

  // R4
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_flag_o && !flag_clr_i |=> sec_flag_o);

  // R3
  flag_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_flag_o && !(enable_i && sec_inc_i) |=> !sec_flag_o);

  // R8
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !irq_o);

  // R7
  level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && !pulse_mode_i |-> irq_o == sec_flag_o);

  // R5
  pulse_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) && pulse_mode_i && $past(pulse_mode_i) && $past(enable_i)
      |-> $past(tick64_i));
endmodule

bind sif_sec_irq sif_sec_irq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick64_i     (tick64_i),
  .sec_inc_i    (sec_inc_i),
  .enable_i     (enable_i),
  .pulse_mode_i (pulse_mode_i),
  .flag_clr_i   (flag_clr_i),
  .sec_flag_o   (sec_flag_o),
  .irq_o        (irq_o)
);

// File: tb/sif_sec_irq_tb_top.sv
`timescale 1ns/1ps
module sif_sec_irq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, sinc = 1'b0, en = 1'b0, pmode = 1'b0, clr = 1'b0;
  logic flag, irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sif_sec_irq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick64_i(tick), .sec_inc_i(sinc),
    .enable_i(en), .pulse_mode_i(pmode), .flag_clr_i(clr),
    .sec_flag_o(flag), .irq_o(irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Apply strobes for one edge, sample 1 ns after the edge, then drop strobes
  task automatic cyc(input logic t, input logic s, input logic c);
    tick = t; sinc = s; clr = c;
    @(posedge clk); #1;
    tick = 1'b0; sinc = 1'b0; clr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0);
  endtask

  task automatic clear_flag();
    cyc(0, 0, 1);
  endtask

  task automatic t_reset();
    chk("R1 flag in reset", flag, 1'b0);
    chk("R1 irq in reset", irq, 1'b0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 flag after reset", flag, 1'b0);
    chk("R1 irq after reset", irq, 1'b0);
  endtask

  task automatic t_disabled();
    en = 1'b0; pmode = 1'b1;
    cyc(1, 1, 0);
    chk("R3 flag stays 0", flag, 1'b0);
    chk("R3 irq stays 0", irq, 1'b0);
    en = 1'b1; #1;
    idle(3); cyc(1, 0, 0);
    chk("R3 no pulse armed", irq, 1'b0);
  endtask

  task automatic t_pulse();
    en = 1'b1; pmode = 1'b1;
    cyc(1, 1, 0);
    chk("R2 flag set", flag, 1'b1);
    chk("R5 pulse starts", irq, 1'b1);
    idle(3);
    chk("R5 pulse held until tick", irq, 1'b1);
    cyc(1, 0, 0);
    chk("R5 pulse ends on next tick", irq, 1'b0);
    chk("R4 flag held", flag, 1'b1);
    idle(2);
    chk("R4 flag still held", flag, 1'b1);
    clear_flag();
    chk("R4 flag cleared", flag, 1'b0);
  endtask

  task automatic t_armed();
    en = 1'b1; pmode = 1'b1;
    cyc(0, 1, 0);
    chk("R6 no pulse before tick", irq, 1'b0);
    chk("R2 flag set off-tick", flag, 1'b1);
    idle(2);
    chk("R6 still waiting", irq, 1'b0);
    cyc(1, 0, 0);
    chk("R6 pulse on next tick", irq, 1'b1);
    cyc(1, 0, 0);
    chk("R6 pulse one period", irq, 1'b0);
    clear_flag();
  endtask

  task automatic t_clr_mid_pulse();
    en = 1'b1; pmode = 1'b1;
    cyc(1, 1, 0);
    clear_flag();
    chk("R9 flag cleared mid pulse", flag, 1'b0);
    chk("R9 pulse survives clear", irq, 1'b1);
    idle(2);
    cyc(1, 0, 0);
    chk("R9 pulse ends on tick", irq, 1'b0);
  endtask

  task automatic t_level();
    en = 1'b1; pmode = 1'b0;
    cyc(1, 1, 0);
    chk("R7 level asserted", irq, 1'b1);
    idle(8); cyc(1, 0, 0);
    chk("R7 level holds past tick", irq, 1'b1);
    cyc(0, 1, 1);
    chk("R4 set wins over clear", flag, 1'b1);
    clear_flag();
    chk("R7 flag cleared", flag, 1'b0);
    chk("R7 level drops on clear", irq, 1'b0);
  endtask

  task automatic t_disable_mid();
    en = 1'b1; pmode = 1'b1;
    cyc(1, 1, 0);
    #0.5 en = 1'b0; #0.5;
    chk("R8 irq off at once", irq, 1'b0);
    chk("R8 flag kept", flag, 1'b1);
    idle(1);
    en = 1'b1; #1;
    chk("R8 pulse cancelled", irq, 1'b0);
    pmode = 1'b0; #1;
    chk("R7 level shows kept flag", irq, 1'b1);
    clear_flag();
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #5;
    t_reset();
    t_disabled();
    t_pulse();
    t_armed();
    t_clr_mid_pulse();
    t_level();
    t_disable_mid();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule